// File: doc/BRIEF.md
# ISA Command and Chip-Select Decoder

This block takes a one-cycle cycle descriptor from the internal bus bridge and turns it into the active-low command strobes and peripheral selects for the ISA side. The descriptor gives the address, whether the cycle targets memory or I/O space, its direction, and three flags: refresh, DMA ownership and external bus-master ownership. Each output is registered on the ISA clock, so it follows its descriptor by exactly one clock edge.

The low-memory strobes open only inside the bottom megabyte. A refresh cycle is the exception: it raises the memory read strobe at any address and never raises the write strobe. One select pin serves two devices. On memory cycles it marks the boot ROM window, and on I/O cycles it marks the two real-time-clock ports. The block also drives the three clock-chip strobes directly from accesses to those ports. It qualifies the incoming 16-bit memory select, gives the DMA address-enable flag, and controls the driver enables of the I/O read and write strobes.

Top module: `isa_cmd_decode`

## Requirements
- R1: `smemr_n` is low in the cycle after a valid descriptor that is either a refresh (at any address and of any type) or a non-refresh memory read with address below LOWMEM_TOP (default 0x100000). Otherwise it is high.
- R2: `smemw_n` is low in the cycle after a valid non-refresh memory write with address below LOWMEM_TOP. A refresh never lowers it.
- R3: `rtc_as_n` is low in the cycle after a valid non-refresh I/O write whose address bits [15:0] equal RTC_INDEX_PORT (default 0x0070).
- R4: `rtc_rw_n` is low after a valid non-refresh I/O write to RTC_DATA_PORT (default 0x0071). `rtc_ds_n` is low after a valid non-refresh I/O read from that port.
- R5: `romrtc_cs_n` is low after a valid non-refresh memory cycle whose address bits [19:0] lie in ROM_BASE..ROM_LIMIT while bits [23:20] are 0x0 or 0xF. It is also low after a valid non-refresh I/O cycle to either clock port, in either direction.
- R6: `mem16_n` copies `mcs16_n_in` in the cycle after a valid non-refresh memory cycle. It is high after I/O cycles, refresh cycles and idle cycles, whatever the level of `mcs16_n_in`.
- R7: `ior_oe_n` and `iow_oe_n` are high (drivers off) in the cycle after `cyc_master` is sampled high. They are low (driving) after it is sampled low, whether or not a cycle is valid.
- R8: `aen` (active high) is high in the cycle after a valid descriptor with `cyc_dma` set, and low otherwise.
- R9: While `rst` is high, and in the cycle after `cyc_valid` is low, every command and select output is high and `aen` is low. During reset both driver enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | ISA clock |
| rst | input | 1 | Synchronous reset, active high |
| cyc_valid | input | 1 | Descriptor is valid this cycle |
| cyc_addr | input | 24 | Cycle address |
| cyc_io | input | 1 | 1 = I/O space, 0 = memory space |
| cyc_write | input | 1 | 1 = write, 0 = read |
| cyc_refresh | input | 1 | Refresh cycle |
| cyc_dma | input | 1 | DMA controller owns the bus |
| cyc_master | input | 1 | External bus master owns the bus |
| mcs16_n_in | input | 1 | Raw 16-bit memory select from the bus |
| smemr_n | output | 1 | Low-memory read strobe |
| smemw_n | output | 1 | Low-memory write strobe |
| romrtc_cs_n | output | 1 | Shared ROM / clock-chip select |
| rtc_as_n | output | 1 | Clock-chip address strobe |
| rtc_ds_n | output | 1 | Clock-chip data strobe |
| rtc_rw_n | output | 1 | Clock-chip write line |
| mem16_n | output | 1 | Qualified 16-bit memory select |
| aen | output | 1 | Address enable for DMA, active high |
| ior_oe_n | output | 1 | I/O read strobe driver enable |
| iow_oe_n | output | 1 | I/O write strobe driver enable |

## Verification
The bench builds the decoder with a narrowed ROM window of 0xF0000..0xF7FFF and leaves the low-memory limit and port numbers at their defaults. The narrow window has both edges inside the last 64 KB of the first megabyte. Biased random addresses can therefore hit the window edges, the one-megabyte edge and the top-of-space alias in the same run. Ports 0x0070/0x0071 and near misses such as 0x0170 are drawn often, so the full 16-bit port compare is exercised against aliases.

// File: rtl/isa_dec_pkg.sv
package isa_dec_pkg;

    localparam int ISA_AW  = 24;
    localparam int WIN_AW  = 20;
    localparam int PORT_W  = 16;
    localparam int HI_W    = ISA_AW - WIN_AW;

    typedef enum logic [1:0] {
        KIND_IDLE    = 2'd0,
        KIND_REFRESH = 2'd1,
        KIND_MEM     = 2'd2,
        KIND_IO      = 2'd3
    } cyc_kind_e;

    typedef struct packed {
        logic              valid;
        logic [ISA_AW-1:0] addr;
        logic              is_io;
        logic              is_wr;
        logic              refresh;
        logic              dma;
        logic              master;
    } isa_cyc_t;

    typedef struct packed {
        logic smemr_n;
        logic smemw_n;
        logic mem16_n;
        logic rom_hit;
    } mem_dec_t;

    typedef struct packed {
        logic as_n;
        logic ds_n;
        logic rw_n;
        logic port_hit;
    } rtc_dec_t;

    typedef struct packed {
        logic smemr_n;
        logic smemw_n;
        logic romrtc_cs_n;
        logic rtc_as_n;
        logic rtc_ds_n;
        logic rtc_rw_n;
        logic mem16_n;
        logic aen;
        logic ior_oe_n;
        logic iow_oe_n;
    } isa_out_t;

    localparam isa_out_t OUT_RESET = '{
        smemr_n:     1'b1,
        smemw_n:     1'b1,
        romrtc_cs_n: 1'b1,
        rtc_as_n:    1'b1,
        rtc_ds_n:    1'b1,
        rtc_rw_n:    1'b1,
        mem16_n:     1'b1,
        aen:         1'b0,
        ior_oe_n:    1'b0,
        iow_oe_n:    1'b0
    };

    function automatic cyc_kind_e classify(input isa_cyc_t c);
        if (!c.valid)       return KIND_IDLE;
        else if (c.refresh) return KIND_REFRESH;
        else if (c.is_io)   return KIND_IO;
        else                return KIND_MEM;
    endfunction

    function automatic logic in_rom_window(input logic [ISA_AW-1:0] a,
                                           input logic [WIN_AW-1:0] base,
                                           input logic [WIN_AW-1:0] limit);
        logic hi_ok;
        hi_ok = (a[ISA_AW-1:WIN_AW] == '0) || (a[ISA_AW-1:WIN_AW] == '1);
        return hi_ok && (a[WIN_AW-1:0] >= base) && (a[WIN_AW-1:0] <= limit);
    endfunction

endpackage

// File: rtl/isa_mem_decode.sv
module isa_mem_decode
    import isa_dec_pkg::*;
#(
    parameter logic [ISA_AW-1:0] LOWMEM_TOP = 24'h100000,
    parameter logic [WIN_AW-1:0] ROM_BASE   = 20'hE0000,
    parameter logic [WIN_AW-1:0] ROM_LIMIT  = 20'hFFFFF
) (
    input  isa_cyc_t  cyc,
    input  cyc_kind_e kind,
    input  logic      mcs16_n_raw,
    output mem_dec_t  dec
);
    logic low_mem;
    logic mem_cyc;

    always_comb begin
        low_mem = (cyc.addr < LOWMEM_TOP);
        mem_cyc = (kind == KIND_MEM);

        dec.smemr_n = 1'b1;
        dec.smemw_n = 1'b1;
        if (kind == KIND_REFRESH) begin
            dec.smemr_n = 1'b0;
        end else if (mem_cyc && low_mem) begin
            dec.smemr_n = cyc.is_wr;
            dec.smemw_n = !cyc.is_wr;
        end

        dec.mem16_n = mem_cyc ? mcs16_n_raw : 1'b1;
        dec.rom_hit = mem_cyc && in_rom_window(cyc.addr, ROM_BASE, ROM_LIMIT);
    end
endmodule

// File: rtl/isa_io_decode.sv
module isa_io_decode
    import isa_dec_pkg::*;
#(
    parameter logic [PORT_W-1:0] RTC_INDEX_PORT = 16'h0070,
    parameter logic [PORT_W-1:0] RTC_DATA_PORT  = 16'h0071
) (
    input  isa_cyc_t  cyc,
    input  cyc_kind_e kind,
    output rtc_dec_t  dec
);
    logic io_cyc;
    logic idx_hit;
    logic dat_hit;

    always_comb begin
        io_cyc  = (kind == KIND_IO);
        idx_hit = io_cyc && (cyc.addr[PORT_W-1:0] == RTC_INDEX_PORT);
        dat_hit = io_cyc && (cyc.addr[PORT_W-1:0] == RTC_DATA_PORT);

        dec.as_n     = !(idx_hit && cyc.is_wr);
        dec.rw_n     = !(dat_hit && cyc.is_wr);
        dec.ds_n     = !(dat_hit && !cyc.is_wr);
        dec.port_hit = idx_hit || dat_hit;
    end
endmodule

// File: rtl/isa_out_stage.sv
module isa_out_stage
    import isa_dec_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  isa_out_t nxt,
    output isa_out_t cur
);
    always_ff @(posedge clk) begin
        if (rst) cur <= OUT_RESET;
        else     cur <= nxt;
    end
endmodule

// File: rtl/isa_cmd_decode.sv
module isa_cmd_decode
    import isa_dec_pkg::*;
#(
    parameter logic [ISA_AW-1:0] LOWMEM_TOP     = 24'h100000,
    parameter logic [WIN_AW-1:0] ROM_BASE       = 20'hE0000,
    parameter logic [WIN_AW-1:0] ROM_LIMIT      = 20'hFFFFF,
    parameter logic [PORT_W-1:0] RTC_INDEX_PORT = 16'h0070,
    parameter logic [PORT_W-1:0] RTC_DATA_PORT  = 16'h0071
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cyc_valid,
    input  logic [ISA_AW-1:0] cyc_addr,
    input  logic              cyc_io,
    input  logic              cyc_write,
    input  logic              cyc_refresh,
    input  logic              cyc_dma,
    input  logic              cyc_master,
    input  logic              mcs16_n_in,
    output logic              smemr_n,
    output logic              smemw_n,
    output logic              romrtc_cs_n,
    output logic              rtc_as_n,
    output logic              rtc_ds_n,
    output logic              rtc_rw_n,
    output logic              mem16_n,
    output logic              aen,
    output logic              ior_oe_n,
    output logic              iow_oe_n
);
    isa_cyc_t  cyc;
    cyc_kind_e kind;
    mem_dec_t  mdec;
    rtc_dec_t  rdec;
    isa_out_t  nxt;
    isa_out_t  cur;

    always_comb begin
        cyc = '{valid: cyc_valid, addr: cyc_addr, is_io: cyc_io,
                is_wr: cyc_write, refresh: cyc_refresh, dma: cyc_dma,
                master: cyc_master};
        kind = classify(cyc);
    end

    isa_mem_decode #(
        .LOWMEM_TOP (LOWMEM_TOP),
        .ROM_BASE   (ROM_BASE),
        .ROM_LIMIT  (ROM_LIMIT)
    ) u_mem (
        .cyc         (cyc),
        .kind        (kind),
        .mcs16_n_raw (mcs16_n_in),
        .dec         (mdec)
    );

    isa_io_decode #(
        .RTC_INDEX_PORT (RTC_INDEX_PORT),
        .RTC_DATA_PORT  (RTC_DATA_PORT)
    ) u_io (
        .cyc  (cyc),
        .kind (kind),
        .dec  (rdec)
    );

    always_comb begin
        nxt.smemr_n     = mdec.smemr_n;
        nxt.smemw_n     = mdec.smemw_n;
        nxt.mem16_n     = mdec.mem16_n;
        nxt.romrtc_cs_n = !(mdec.rom_hit || rdec.port_hit);
        nxt.rtc_as_n    = rdec.as_n;
        nxt.rtc_ds_n    = rdec.ds_n;
        nxt.rtc_rw_n    = rdec.rw_n;
        nxt.aen         = cyc.valid && cyc.dma;
        nxt.ior_oe_n    = cyc.master;
        nxt.iow_oe_n    = cyc.master;
    end

    isa_out_stage u_out (
        .clk (clk),
        .rst (rst),
        .nxt (nxt),
        .cur (cur)
    );

    always_comb begin
        smemr_n     = cur.smemr_n;
        smemw_n     = cur.smemw_n;
        romrtc_cs_n = cur.romrtc_cs_n;
        rtc_as_n    = cur.rtc_as_n;
        rtc_ds_n    = cur.rtc_ds_n;
        rtc_rw_n    = cur.rtc_rw_n;
        mem16_n     = cur.mem16_n;
        aen         = cur.aen;
        ior_oe_n    = cur.ior_oe_n;
        iow_oe_n    = cur.iow_oe_n;
    end

    p_smemr_window_r1: assert property (@(posedge clk) disable iff (rst)
        !smemr_n |-> $past(cyc_valid && (cyc_refresh ||
                     (!cyc_io && !cyc_write && cyc_addr < LOWMEM_TOP))));

    p_smemw_window_r2: assert property (@(posedge clk) disable iff (rst)
        !smemw_n |-> $past(cyc_valid && !cyc_refresh && !cyc_io &&
                           cyc_write && cyc_addr < LOWMEM_TOP));

    p_refresh_no_write_r2: assert property (@(posedge clk) disable iff (rst)
        (cyc_valid && cyc_refresh) |=> (smemw_n && !smemr_n));

    p_rtc_as_port_r3: assert property (@(posedge clk) disable iff (rst)
        !rtc_as_n |-> $past(cyc_valid && !cyc_refresh && cyc_io && cyc_write &&
                            cyc_addr[PORT_W-1:0] == RTC_INDEX_PORT));

    p_rtc_one_strobe_r4: assert property (@(posedge clk) disable iff (rst)
        $countones({~rtc_as_n, ~rtc_ds_n, ~rtc_rw_n}) <= 1);

    p_rtc_strobe_cs_r5: assert property (@(posedge clk) disable iff (rst)
        (!rtc_as_n || !rtc_ds_n || !rtc_rw_n) |-> !romrtc_cs_n);

    p_mem16_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        (!cyc_valid || cyc_io || cyc_refresh) |=> mem16_n);

    p_master_oe_r7: assert property (@(posedge clk) disable iff (rst)
        cyc_master |=> (ior_oe_n && iow_oe_n));

    p_aen_dma_r8: assert property (@(posedge clk) disable iff (rst)
        aen |-> $past(cyc_valid && cyc_dma));

    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        !cyc_valid |=> (smemr_n && smemw_n && romrtc_cs_n && rtc_as_n &&
                        rtc_ds_n && rtc_rw_n && !aen));
endmodule

// File: tb/isa_cmd_decode_bench.sv
`timescale 1ns/1ps
module isa_cmd_decode_bench;
    localparam logic [23:0] B_LOW   = 24'h100000;
    localparam logic [19:0] B_RBASE = 20'hF0000;
    localparam logic [19:0] B_RLIM  = 20'hF7FFF;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic v, io, wr, rf, dma, mst, m16;
    logic [23:0] addr;
    logic smemr_n, smemw_n, romrtc_cs_n, rtc_as_n, rtc_ds_n, rtc_rw_n;
    logic mem16_n, aen, ior_oe_n, iow_oe_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    isa_cmd_decode #(
        .ROM_BASE  (B_RBASE),
        .ROM_LIMIT (B_RLIM)
    ) u_isa_cmd_decode (
        .clk(clk), .rst(rst), .cyc_valid(v), .cyc_addr(addr), .cyc_io(io),
        .cyc_write(wr), .cyc_refresh(rf), .cyc_dma(dma), .cyc_master(mst),
        .mcs16_n_in(m16), .smemr_n(smemr_n), .smemw_n(smemw_n),
        .romrtc_cs_n(romrtc_cs_n), .rtc_as_n(rtc_as_n), .rtc_ds_n(rtc_ds_n),
        .rtc_rw_n(rtc_rw_n), .mem16_n(mem16_n), .aen(aen),
        .ior_oe_n(ior_oe_n), .iow_oe_n(iow_oe_n)
    );

    task automatic chk(input string req, input string name, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b (addr %h io %b wr %b rf %b)",
                     req, name, act, exp, addr, io, wr, rf);
        end
    endtask

    function automatic logic rom_win(input logic [23:0] a);
        return (a[23:20] == 4'h0 || a[23:20] == 4'hF) &&
               a[19:0] >= B_RBASE && a[19:0] <= B_RLIM;
    endfunction

    task automatic apply(input logic iv, input logic [23:0] ia, input logic iio,
                         input logic iwr, input logic irf, input logic idma,
                         input logic imst, input logic im16);
        logic mem, iop, p70, p71;
        @(negedge clk);
        v = iv; addr = ia; io = iio; wr = iwr; rf = irf; dma = idma; mst = imst; m16 = im16;
        mem = iv && !irf && !iio;
        iop = iv && !irf && iio;
        p70 = iop && ia[15:0] == 16'h0070;
        p71 = iop && ia[15:0] == 16'h0071;
        @(posedge clk);
        #2;
        chk("R1", "smemr_n", smemr_n, !((iv && irf) || (mem && !iwr && ia < B_LOW)));
        chk("R2", "smemw_n", smemw_n, !(mem && iwr && ia < B_LOW));
        chk("R3", "rtc_as_n", rtc_as_n, !(p70 && iwr));
        chk("R4", "rtc_rw_n", rtc_rw_n, !(p71 && iwr));
        chk("R4", "rtc_ds_n", rtc_ds_n, !(p71 && !iwr));
        chk("R5", "romrtc_cs_n", romrtc_cs_n, !((mem && rom_win(ia)) || p70 || p71));
        chk("R6", "mem16_n", mem16_n, mem ? im16 : 1'b1);
        chk("R7", "ior_oe_n", ior_oe_n, imst);
        chk("R7", "iow_oe_n", iow_oe_n, imst);
        chk("R8", "aen", aen, iv && idma);
    endtask

    function automatic logic [23:0] pick_addr(input int unsigned sel, input int unsigned r);
        case (sel % 8)
            0: return 24'h0F0000 + (r % 24'h10000);
            1: return 24'h0FFFF8 + (r % 16);
            2: return 24'hFF0000 + (r % 24'h10000);
            3: return {8'h00, 16'h0070 + 16'(r % 3)};
            4: return {8'h01, 16'h0170 + 16'(r % 2)};
            5: return 24'h0EFFFC + (r % 8);
            default: return r[23:0];
        endcase
    endfunction

    initial begin
        #(200000 * 20);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        v = 0; addr = '0; io = 0; wr = 0; rf = 0; dma = 0; mst = 0; m16 = 1;
        rst = 1'b1;
        @(posedge clk); @(posedge clk); #2;
        // R9: reset state
        chk("R9", "smemr_n", smemr_n, 1'b1);
        chk("R9", "smemw_n", smemw_n, 1'b1);
        chk("R9", "romrtc_cs_n", romrtc_cs_n, 1'b1);
        chk("R9", "rtc_as_n", rtc_as_n, 1'b1);
        chk("R9", "aen", aen, 1'b0);
        chk("R9", "ior_oe_n", ior_oe_n, 1'b0);
        @(negedge clk); rst = 1'b0;

        // R1/R2 one-megabyte edge
        apply(1, 24'h0FFFFF, 0, 0, 0, 0, 0, 1);
        apply(1, 24'h100000, 0, 0, 0, 0, 0, 1);
        apply(1, 24'h0FFFFF, 0, 1, 0, 0, 0, 1);
        apply(1, 24'h100000, 0, 1, 0, 0, 0, 1);
        // R1/R2 refresh above 1 MB, write flag set
        apply(1, 24'h3A0000, 0, 1, 1, 0, 0, 0);
        apply(1, 24'h000070, 1, 1, 1, 0, 0, 0);
        // R5 ROM window edges and alias
        apply(1, 24'h0EFFFF, 0, 0, 0, 0, 0, 1);
        apply(1, 24'h0F0000, 0, 0, 0, 0, 0, 1);
        apply(1, 24'h0F7FFF, 0, 1, 0, 0, 0, 1);
        apply(1, 24'h0F8000, 0, 0, 0, 0, 0, 1);
        apply(1, 24'hFF0000, 0, 0, 0, 0, 0, 0);
        apply(1, 24'h5F0000, 0, 0, 0, 0, 0, 0);
        // R3/R4/R5 clock ports
        apply(1, 24'h000070, 1, 1, 0, 0, 0, 0);
        apply(1, 24'h000070, 1, 0, 0, 0, 0, 0);
        apply(1, 24'h000071, 1, 1, 0, 0, 0, 0);
        apply(1, 24'h000071, 1, 0, 0, 0, 0, 0);
        apply(1, 24'h000072, 1, 1, 0, 0, 0, 0);
        apply(1, 24'h000170, 1, 1, 0, 0, 0, 0);
        // R7 master, R8 dma, R9 idle with busy-looking inputs
        apply(1, 24'h000300, 1, 0, 0, 0, 1, 0);
        apply(0, 24'h000071, 1, 1, 0, 1, 1, 0);
        apply(1, 24'h000400, 0, 1, 0, 1, 0, 0);
        apply(0, 24'h0F0000, 0, 0, 1, 0, 0, 0);

        void'($urandom(32'd1234));
        for (int i = 0; i < 400; i++) begin
            int unsigned r = $urandom();
            apply(r[0] | r[1], pick_addr($urandom(), $urandom()), r[2], r[3],
                  (r[7:4] == 4'h0), r[8] & r[9], (r[12:10] == 3'd0), r[13]);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule